// File: doc/BRIEF.md
# Dual-Clock Elasticity Buffer

This block moves a stream of 5-bit code groups from the clock recovered out of the incoming line into the station's own local clock domain. Every receive clock edge writes one code group into a ring of eight registers, and every local clock edge reads one out. Because the two clocks are nominally equal but never identical, the gap between the write pointer and the read pointer slowly drifts. The block corrects this drift during the idle time between packets.

When the receive side sees enough consecutive idle code groups, it stores the current write address in a holding register and toggles a single request line. That line is the only control signal that crosses into the local domain. The local side passes it through a two-flop synchronizer. It then moves the read pointer to a position derived from the held address, so the read pointer trails the write pointer by about half the ring.

A separate detector compares the two Gray-coded pointers on two local clock phases that are 90 degrees apart. It raises a sticky slip flag when the pointers coincide. While that flag is set, the block sends out a fixed violation code group instead of reading a register that may be changing.

Top module: `elastic_retimer`

## Requirements
- R1: While `lcl_rst` is high, and on the first local cycle after it is released, `lcl_sym` is 0 and `slip_err` is 0.
- R2: The idle run is counted from the first idle after a non-idle code group, or after reset. On the receive edge that samples the MIN_GAP-th consecutive `rx_idle`=1 (default 4), the write address of that edge is held and one re-centre request is issued. Only one request is issued per idle run. The read pointer is loaded with the held address advanced by 8/2 + LAG_COMP positions, modulo 8; with the defaults this is the held address itself. The code group written on that capturing edge appears on `lcl_sym` after the 4th rising `lcl_clk` edge that follows the capturing edge.
- R3: With equal clock rates, once a re-centre has taken effect, every code group written afterwards appears on `lcl_sym` exactly once and in write order, one per `lcl_clk` edge. A later re-centre does not break this order. Both pointers are Gray coded and change by one bit per step, except at a load.
- R4: An idle run shorter than MIN_GAP code groups issues no request. As a result, a `slip_err` that is already set stays set.
- R5: Pointer equality is sampled on the rising edge of `lcl_clk_q` and again on the next rising edge of `lcl_clk`. If both samples are true, `slip_err` is set on the following `lcl_clk` edge. It then stays set until the next read-pointer load.
- R6: While `slip_err` is 1, `lcl_sym` carries the violation code 5'b00100. This includes the cycle in which the flag is set.
- R7: A read-pointer load clears `slip_err` on that same edge. Equality samples taken before the load cannot set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_idle | input | 1 | High when the current code group belongs to an interpacket gap |
| rx_sym | input | SYM_W | Received code group |
| lcl_clk | input | 1 | Local reference clock |
| lcl_clk_q | input | 1 | Local clock shifted by 90 degrees |
| lcl_rst | input | 1 | Synchronous active-high reset, local domain |
| lcl_sym | output | SYM_W | Re-timed code group, registered on lcl_clk |
| slip_err | output | 1 | Sticky pointer-collision flag |

## Verification
The properties assume the following about the inputs:
- `lcl_clk_q` is a fixed quarter-period delay of `lcl_clk`.
- Both resets are applied together.
- Idle runs that trigger a capture are spaced far enough apart that the holding register stays unchanged until the local side has loaded from it.

The stimulus meets these assumptions. It runs the two clocks at the same period with a fixed phase offset and starts each packet phase with a long idle run. Collisions are provoked only by halting the receive clock. This lets the read pointer sweep past a frozen write pointer, which is what a lost recovered clock or a badly skewed rate would cause.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int EB_PTR_W = 3;
  localparam int EB_DEPTH = 1 << EB_PTR_W;

  typedef logic [EB_PTR_W-1:0] eb_ptr_t;

  function automatic eb_ptr_t b2g(eb_ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic eb_ptr_t g2b(eb_ptr_t g);
    eb_ptr_t b;
    b[EB_PTR_W-1] = g[EB_PTR_W-1];
    for (int i = EB_PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic eb_ptr_t gray_step(eb_ptr_t g);
    return b2g(eb_ptr_t'(g2b(g) + eb_ptr_t'(1)));
  endfunction
endpackage

// File: rtl/eb_store.sv
module eb_store
  import eb_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         wclk,
  input  eb_ptr_t      waddr,
  input  logic [W-1:0] wdata,
  input  eb_ptr_t      raddr,
  output logic [W-1:0] rdata
);
  logic [W-1:0] cells [EB_DEPTH];

  always_ff @(posedge wclk) begin
    cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
  import eb_pkg::*;
#(
  parameter int MIN_GAP = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    idle,
  output eb_ptr_t wr_g,
  output eb_ptr_t hold_g,
  output logic    req_tgl
);
  localparam int CW = $clog2(MIN_GAP + 1);

  logic [CW-1:0] run_cnt;
  logic          armed;
  logic          capture;

  // capture on the edge that samples the MIN_GAP-th idle of the run
  assign capture = idle && armed && (run_cnt == CW'(MIN_GAP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_g    <= '0;
      hold_g  <= '0;
      req_tgl <= 1'b0;
      run_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      wr_g <= gray_step(wr_g);
      if (!idle) begin
        run_cnt <= '0;
        armed   <= 1'b1;
      end else if (capture) begin
        hold_g  <= wr_g;
        req_tgl <= ~req_tgl;
        armed   <= 1'b0;
      end else if (run_cnt < CW'(MIN_GAP - 1)) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eb_collide.sv
module eb_collide
  import eb_pkg::*;
(
  input  logic    clk,
  input  logic    clk_q,
  input  logic    rst,
  input  logic    clr,
  input  eb_ptr_t wr_g,
  input  eb_ptr_t rd_g,
  output logic    hit
);
  logic same;
  logic samp_q;
  logic samp_q_l;
  logic samp_e;

  assign same = (wr_g == rd_g);

  // quarter-phase sample
  always_ff @(posedge clk_q) begin
    if (rst) samp_q <= 1'b0;
    else     samp_q <= same;
  end

  // main-edge sample plus transfer of the shifted sample
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      samp_e   <= 1'b0;
      samp_q_l <= 1'b0;
    end else begin
      samp_e   <= same;
      samp_q_l <= samp_q;
    end
  end

  assign hit = samp_e & samp_q_l;
endmodule

// File: rtl/eb_rd_side.sv
module eb_rd_side
  import eb_pkg::*;
#(
  parameter int               SYM_W    = 5,
  parameter int               LAG_COMP = 4,
  parameter logic [SYM_W-1:0] VIOL     = SYM_W'(4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_tgl,
  input  eb_ptr_t          hold_g,
  input  logic [SYM_W-1:0] rdata,
  input  logic             hit,
  output eb_ptr_t          rd_g,
  output logic             load,
  output logic [SYM_W-1:0] sym,
  output logic             err
);
  localparam int OFS = (EB_DEPTH / 2 + LAG_COMP) % EB_DEPTH;

  logic sync_a;
  logic sync_b;
  logic seen;
  logic err_nx;

  assign load   = sync_b ^ seen;
  assign err_nx = load ? 1'b0 : (err | hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      seen   <= 1'b0;
      rd_g   <= b2g(eb_ptr_t'(EB_DEPTH / 2));
      err    <= 1'b0;
      sym    <= '0;
    end else begin
      sync_a <= req_tgl;
      sync_b <= sync_a;
      seen   <= sync_b;
      if (load) rd_g <= b2g(eb_ptr_t'(g2b(hold_g) + eb_ptr_t'(OFS)));
      else      rd_g <= gray_step(rd_g);
      err <= err_nx;
      sym <= err_nx ? VIOL : rdata;
    end
  end
endmodule

// File: rtl/elastic_retimer.sv
module elastic_retimer
  import eb_pkg::*;
#(
  parameter int               SYM_W    = 5,
  parameter int               MIN_GAP  = 4,
  parameter int               LAG_COMP = 4,
  parameter logic [SYM_W-1:0] VIOL     = SYM_W'(4)
) (
  input  logic             rx_clk,
  input  logic             rx_rst,
  input  logic             rx_idle,
  input  logic [SYM_W-1:0] rx_sym,
  input  logic             lcl_clk,
  input  logic             lcl_clk_q,
  input  logic             lcl_rst,
  output logic [SYM_W-1:0] lcl_sym,
  output logic             slip_err
);
  eb_ptr_t          wr_g;
  eb_ptr_t          rd_g;
  eb_ptr_t          hold_g;
  logic             req_tgl;
  logic             rd_load;
  logic             hit;
  logic [SYM_W-1:0] rdata;

  eb_store #(.W(SYM_W)) i_store (
    .wclk (rx_clk),
    .waddr(wr_g),
    .wdata(rx_sym),
    .raddr(rd_g),
    .rdata(rdata)
  );

  eb_wr_side #(.MIN_GAP(MIN_GAP)) i_wr (
    .clk    (rx_clk),
    .rst    (rx_rst),
    .idle   (rx_idle),
    .wr_g   (wr_g),
    .hold_g (hold_g),
    .req_tgl(req_tgl)
  );

  eb_collide i_coll (
    .clk  (lcl_clk),
    .clk_q(lcl_clk_q),
    .rst  (lcl_rst),
    .clr  (rd_load),
    .wr_g (wr_g),
    .rd_g (rd_g),
    .hit  (hit)
  );

  eb_rd_side #(.SYM_W(SYM_W), .LAG_COMP(LAG_COMP), .VIOL(VIOL)) i_rd (
    .clk    (lcl_clk),
    .rst    (lcl_rst),
    .req_tgl(req_tgl),
    .hold_g (hold_g),
    .rdata  (rdata),
    .hit    (hit),
    .rd_g   (rd_g),
    .load   (rd_load),
    .sym    (lcl_sym),
    .err    (slip_err)
  );
endmodule

// File: rtl/eb_checker.sv
module eb_checker
  import eb_pkg::*;
#(
  parameter int               SYM_W = 5,
  parameter logic [SYM_W-1:0] VIOL  = SYM_W'(4)
) (
  input logic             rx_clk,
  input logic             rx_rst,
  input logic             lcl_clk,
  input logic             lcl_rst,
  input eb_ptr_t          wr_g,
  input eb_ptr_t          rd_g,
  input logic             rd_load,
  input logic             slip_err,
  input logic [SYM_W-1:0] lcl_sym
);
  assert_reset_R1: assert property (@(posedge lcl_clk) disable iff (lcl_rst)
    $past(lcl_rst) |-> (!slip_err && lcl_sym == '0));

  assert_wr_gray_R3: assert property (@(posedge rx_clk) disable iff (rx_rst)
    $countones(wr_g ^ $past(wr_g)) <= 1);

  assert_rd_gray_R3: assert property (@(posedge lcl_clk) disable iff (lcl_rst)
    !rd_load |=> ($countones(rd_g ^ $past(rd_g)) <= 1));

  assert_sticky_R5: assert property (@(posedge lcl_clk) disable iff (lcl_rst)
    (slip_err && !rd_load) |=> slip_err);

  assert_viol_R6: assert property (@(posedge lcl_clk) disable iff (lcl_rst)
    slip_err |-> (lcl_sym == VIOL));

  assert_clear_R7: assert property (@(posedge lcl_clk) disable iff (lcl_rst)
    rd_load |=> !slip_err);
endmodule

bind elastic_retimer eb_checker #(.SYM_W(SYM_W), .VIOL(VIOL)) i_chk (
  .rx_clk  (rx_clk),
  .rx_rst  (rx_rst),
  .lcl_clk (lcl_clk),
  .lcl_rst (lcl_rst),
  .wr_g    (wr_g),
  .rd_g    (rd_g),
  .rd_load (rd_load),
  .slip_err(slip_err),
  .lcl_sym (lcl_sym)
);

// File: tb/test_elastic_retimer.sv
module test_elastic_retimer;
  localparam int         CLK_NS  = 20;
  localparam int         MIN_GAP = 4;
  localparam logic [4:0] IDLE    = 5'b11111;
  localparam logic [4:0] VIOL    = 5'b00100;

  logic       rx_clk = 1'b0;
  logic       lcl_clk = 1'b0;
  logic       lcl_clk_q = 1'b0;
  logic       rx_run = 1'b1;
  logic       rx_rst = 1'b1;
  logic       lcl_rst = 1'b1;
  logic       rx_idle = 1'b0;
  logic [4:0] rx_sym = '0;
  logic [4:0] lcl_sym;
  logic       slip_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [4:0] exp_q[$];
  bit         tracking = 0;
  int         m_cnt = 0;
  bit         m_armed = 1;
  event       cap_ev;

  elastic_retimer i_elastic_retimer (
    .rx_clk   (rx_clk),
    .rx_rst   (rx_rst),
    .rx_idle  (rx_idle),
    .rx_sym   (rx_sym),
    .lcl_clk  (lcl_clk),
    .lcl_clk_q(lcl_clk_q),
    .lcl_rst  (lcl_rst),
    .lcl_sym  (lcl_sym),
    .slip_err (slip_err)
  );

  initial forever #(CLK_NS/2) lcl_clk = ~lcl_clk;
  initial begin
    #(CLK_NS/4);
    forever #(CLK_NS/2) lcl_clk_q = ~lcl_clk_q;
  end
  initial begin
    #6;
    forever begin
      #(CLK_NS/2);
      rx_clk = rx_run ? ~rx_clk : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: one code group per receive cycle, with a model of gap capture
  task automatic push(input logic [4:0] v, input bit idle);
    bit cap;
    @(negedge rx_clk);
    rx_sym  = v;
    rx_idle = idle;
    cap = 0;
    if (!idle) begin
      m_cnt = 0;
      m_armed = 1;
    end else if (m_armed && m_cnt == MIN_GAP - 1) begin
      cap = 1;
      m_armed = 0;
    end else if (m_cnt < MIN_GAP - 1) begin
      m_cnt++;
    end
    if (cap && !tracking) begin
      tracking = 1;
      -> cap_ev;
    end
    if (tracking) exp_q.push_back(v);
  endtask

  task automatic burst(input int idles, input int data, input int base);
    for (int i = 0; i < idles; i++) push(IDLE, 1'b1);
    for (int i = 0; i < data; i++) push(5'((base + i) % 31), 1'b0);
  endtask

  // monitor: wait for the capturing edge, then compare the stream
  task automatic monitor(input int n);
    logic [4:0] e;
    @(cap_ev);
    repeat (4) @(posedge lcl_clk);
    #3;
    chk(slip_err == 1'b0, "R7 flag clear after load", int'(slip_err), 0);
    for (int k = 0; k < n; k++) begin
      @(posedge lcl_clk);
      #3;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 queue empty", int'(lcl_sym), -1);
      end else begin
        e = exp_q.pop_front();
        if (k == 0) chk(lcl_sym == e && e == IDLE, "R2 captured group first", int'(lcl_sym), int'(e));
        else        chk(lcl_sym == e, "R3 in-order stream", int'(lcl_sym), int'(e));
      end
    end
  endtask

  initial begin
    repeat (5) @(posedge lcl_clk);
    #3;
    chk(lcl_sym == '0, "R1 reset data", int'(lcl_sym), 0);
    chk(slip_err == 1'b0, "R1 reset flag", int'(slip_err), 0);
    @(negedge lcl_clk);
    rx_rst = 1'b0;
    lcl_rst = 1'b0;
    @(posedge lcl_clk);
    #3;
    chk(slip_err == 1'b0, "R1 flag after release", int'(slip_err), 0);

    // phase A: re-centre and ordered stream across a second gap
    fork
      begin
        burst(8, 40, 0);
        burst(6, 20, 7);
      end
      monitor(60);
    join

    // phase B: receive clock halts, read pointer sweeps into write pointer
    rx_run = 1'b0;
    repeat (20) @(posedge lcl_clk);
    #3;
    chk(slip_err == 1'b1, "R5 collision flag", int'(slip_err), 1);
    chk(lcl_sym == VIOL, "R6 violation code", int'(lcl_sym), int'(VIOL));
    for (int i = 0; i < 3; i++) begin
      @(posedge lcl_clk);
      #3;
      chk(lcl_sym == VIOL, "R6 violation held", int'(lcl_sym), int'(VIOL));
      chk(slip_err == 1'b1, "R5 flag sticky", int'(slip_err), 1);
    end

    // phase C: short idle run must not re-centre
    rx_run = 1'b1;
    tracking = 0;
    exp_q.delete();
    burst(0, 10, 3);
    burst(MIN_GAP - 1, 10, 11);
    repeat (10) @(posedge lcl_clk);
    #3;
    chk(slip_err == 1'b1, "R4 short gap keeps flag", int'(slip_err), 1);
    chk(lcl_sym == VIOL, "R4 short gap keeps violation", int'(lcl_sym), int'(VIOL));

    // phase D: long gap clears the flag and restores the stream
    fork
      burst(8, 30, 5);
      monitor(30);
    join

    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end
endmodule